// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block holds the priority logic of an eight-input interrupt controller. Each cycle it takes the pending request vector, the mask vector and the in-service vector, together with a three-bit rotation offset and two mode flags. From these it decides whether an unmasked pending request outranks every interrupt that is currently in service. When one does, it reports the number of the winning input line and raises the controller's interrupt output.

Priority rotates. The line selected by the offset ranks highest, and the ranking continues upward from it and wraps around. The in-service side is searched with the same ranking before the two results are compared. Two modes change what counts as in service. In special-mask mode, lines that are masked no longer block lower-ranked requests. In nested mode on a cascade master, the cascade input never blocks a request.

One output register stage is fitted by default to meet timing. A parameter can remove it and leave the path purely combinational.

Top module: `prio_resolver`

## Requirements
- R1: Only lines whose request bit is 1 and whose mask bit is 0 are candidates. A masked request never wins.
- R2: Candidates rank by rotated index p = (line - offset_i) mod 8, and the smallest p wins. With offset_i = 0, line 0 ranks highest and line 7 lowest.
- R3: When no candidate exists, irq_valid_o is 0 and irq_num_o is 0.
- R4: The current level is the smallest rotated index among the effective in-service bits, using the same offset. A request fires only when its rotated index is strictly smaller than the current level. An equal or larger index gives no interrupt.
- R5: When no effective in-service bit is set, any candidate fires.
- R6: When special_mask_i is 1, in-service bits whose mask bit is 1 are left out of the current level.
- R7: When nest_mode_i and master_i are both 1, in-service bit 2 (the cascade line) is left out of the current level. If either flag is 0, that bit counts as normal.
- R8: irq_num_o gives the physical line of the winner, which is (p + offset_i) mod 8.
- R9: int_o is equal to irq_valid_o at all times.
- R10: With the default single output stage, the outputs reflect the inputs that were present at the previous rising clock edge. While rst_ni is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 = masked |
| isr_i | input | 8 | In-service vector |
| offset_i | input | 3 | Line that ranks highest |
| special_mask_i | input | 1 | Masked lines leave the in-service check |
| nest_mode_i | input | 1 | Nested mode flag |
| master_i | input | 1 | Unit is the cascade master |
| irq_valid_o | output | 1 | A request outranks the current level |
| irq_num_o | output | 3 | Winning line, 0 when not valid |
| int_o | output | 1 | Interrupt output to the processor |

## Verification
Several properties are checked by assertions on every cycle. A reported winner is always an unmasked pending line. A line's rotated search result always points at a set bit. The winner is never a line that is effectively in service. Filtered in-service vectors never contain masked lines in special-mask mode, and never contain the cascade bit in nested master mode. Other behaviours can only be shown by the bench scenarios against its reference model: the exact ranking under each offset, the strict-versus-equal comparison, and the one-cycle output latency.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned LINES_DEF   = 8;
  localparam int unsigned CASCADE_DEF = 2;

  typedef enum logic {
    STAGE_COMB = 1'b0,
    STAGE_REG  = 1'b1
  } stage_e;
endpackage

// File: rtl/rot_search.sv
module rot_search #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] off_i,
  output logic [W:0]   prio_o,
  output logic [W-1:0] line_o,
  output logic         found_o
);
  logic [N-1:0] rot;

  // rot[p] is the physical line that sits at rank p
  for (genvar p = 0; p < N; p++) begin : g_rot
    logic [W-1:0] idx;
    assign idx    = W'(p) + off_i;
    assign rot[p] = vec_i[idx];
  end

  always_comb begin
    prio_o = (W+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) prio_o = (W+1)'(p);
    end
  end

  assign line_o  = prio_o[W-1:0] + off_i;
  assign found_o = |rot;

  AST_LINE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> vec_i[line_o]);  // R2
  AST_EMPTY_SENTINEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i == '0) |-> (prio_o == (W+1)'(N)));  // R3
endmodule

// File: rtl/isr_filter.sv
module isr_filter #(
  parameter int unsigned N       = 8,
  parameter int unsigned CASCADE = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] isr_i,
  input  logic [N-1:0] mask_i,
  input  logic         special_mask_i,
  input  logic         nest_mode_i,
  input  logic         master_i,
  output logic [N-1:0] eff_o
);
  logic [N-1:0] casc_bit;
  logic [N-1:0] keep_mask;
  logic [N-1:0] keep_casc;

  assign casc_bit  = N'(1) << CASCADE;
  assign keep_mask = special_mask_i ? ~mask_i : '1;
  assign keep_casc = (nest_mode_i && master_i) ? ~casc_bit : '1;
  assign eff_o     = isr_i & keep_mask & keep_casc;

  AST_SMM_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_mask_i |-> ((eff_o & mask_i) == '0));  // R6
  AST_CASCADE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_mode_i && master_i) |-> !eff_o[CASCADE]);  // R7
  AST_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eff_o & ~isr_i) == '0));  // R4
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned W     = 3,
  parameter prio_pkg::stage_e MODE = prio_pkg::STAGE_REG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] num_i,
  output logic         valid_o,
  output logic [W-1:0] num_o
);
  if (MODE == prio_pkg::STAGE_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        num_o   <= '0;
      end else begin
        valid_o <= valid_i;
        num_o   <= valid_i ? num_i : '0;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign num_o   = valid_i ? num_i : '0;
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int unsigned N       = prio_pkg::LINES_DEF,
  parameter int unsigned CASCADE = prio_pkg::CASCADE_DEF,
  parameter prio_pkg::stage_e MODE = prio_pkg::STAGE_REG,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] isr_i,
  input  logic [W-1:0] offset_i,
  input  logic         special_mask_i,
  input  logic         nest_mode_i,
  input  logic         master_i,
  output logic         irq_valid_o,
  output logic [W-1:0] irq_num_o,
  output logic         int_o
);
  logic [N-1:0] cand;
  logic [N-1:0] eff_isr;
  logic [W:0]   req_prio, cur_prio;
  logic [W-1:0] req_line, cur_line;
  logic         req_found, cur_found;
  logic         hit;

  assign cand = req_i & ~mask_i;

  rot_search #(.N(N)) u_req_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vec_i   (cand),
    .off_i   (offset_i),
    .prio_o  (req_prio),
    .line_o  (req_line),
    .found_o (req_found)
  );

  isr_filter #(.N(N), .CASCADE(CASCADE)) u_isr_filter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .isr_i          (isr_i),
    .mask_i         (mask_i),
    .special_mask_i (special_mask_i),
    .nest_mode_i    (nest_mode_i),
    .master_i       (master_i),
    .eff_o          (eff_isr)
  );

  rot_search #(.N(N)) u_cur_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vec_i   (eff_isr),
    .off_i   (offset_i),
    .prio_o  (cur_prio),
    .line_o  (cur_line),
    .found_o (cur_found)
  );

  // strict compare; empty in-service side ranks below every request
  assign hit = req_found && (!cur_found || (req_prio < cur_prio));

  out_stage #(.W(W), .MODE(MODE)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (hit),
    .num_i   (req_line),
    .valid_o (irq_valid_o),
    .num_o   (irq_num_o)
  );

  assign int_o = irq_valid_o;

  AST_WIN_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (req_i[req_line] && !mask_i[req_line]));  // R1
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand == '0) |-> !hit);  // R3
  AST_NOT_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> !eff_isr[req_line]);  // R4
  AST_DISTINCT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cur_found) |-> (cur_line != req_line));  // R4
  AST_EMPTY_ISR_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eff_isr == '0) && (cand != '0)) |-> hit);  // R5
  AST_NUM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> (irq_num_o == '0));  // R3
endmodule

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0, mask_i = '0, isr_i = '0;
  logic [2:0] offset_i = '0;
  logic       special_mask_i = 1'b0, nest_mode_i = 1'b0, master_i = 1'b0;
  logic       irq_valid_o, int_o;
  logic [2:0] irq_num_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  prio_resolver dut (
    .clk_i, .rst_ni, .req_i, .mask_i, .isr_i, .offset_i,
    .special_mask_i, .nest_mode_i, .master_i,
    .irq_valid_o, .irq_num_o, .int_o
  );

  function automatic logic [3:0] ref_model(input logic [7:0] rq, mk, is,
      input logic [2:0] of, input logic sm, nm, ms);
    logic [7:0] cnd, eis;
    int rp, cp;
    cnd = rq & ~mk;
    eis = is;
    if (sm) eis = eis & ~mk;
    if (nm && ms) eis[2] = 1'b0;
    rp = 8; cp = 8;
    for (int p = 7; p >= 0; p--) begin
      if (cnd[(p + of) % 8]) rp = p;
      if (eis[(p + of) % 8]) cp = p;
    end
    if (rp < cp) return {1'b1, 3'((rp + of) % 8)};
    return 4'b0;
  endfunction

  task automatic check_one(input logic [3:0] exp, input string tag);
    n_checks++;
    if ({irq_valid_o, irq_num_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: valid/num = %b/%0d, expected %b/%0d",
               tag, irq_valid_o, irq_num_o, exp[3], exp[2:0]);
    end
    n_checks++;
    if (int_o !== irq_valid_o) begin
      n_fail++;
      $display("FAIL R9: int_o = %b, expected %b", int_o, irq_valid_o);
    end
  endtask

  task automatic drain();
    if (exp_q.size() > 0) check_one(exp_q.pop_front(), tag_q.pop_front());
  endtask

  task automatic step(input logic [7:0] rq, mk, is, input logic [2:0] of,
      input logic sm, nm, ms, input string tag);
    @(negedge clk_i);
    drain();
    req_i = rq; mask_i = mk; isr_i = is; offset_i = of;
    special_mask_i = sm; nest_mode_i = nm; master_i = ms;
    exp_q.push_back(ref_model(rq, mk, is, of, sm, nm, ms));
    tag_q.push_back(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL R10: watchdog expired, actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    req_i = 8'hFF;
    repeat (2) @(negedge clk_i);
    check_one(4'b0, "R10 reset state");
    rst_ni = 1'b1;
    req_i = '0;
    @(negedge clk_i);
    check_one(4'b0, "R10 after release");

    step(8'h01, 8'h01, 8'h00, 3'd0, 0, 0, 0, "R1 masked only");
    step(8'h03, 8'h01, 8'h00, 3'd0, 0, 0, 0, "R1 masked skipped");
    step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R3 none pending");
    step(8'h11, 8'h00, 8'h00, 3'd5, 0, 0, 0, "R2 rotated pick");
    step(8'h30, 8'h00, 8'h00, 3'd5, 0, 0, 0, "R2 offset line first");
    step(8'h80, 8'h00, 8'h00, 3'd7, 0, 0, 0, "R8 line from offset");
    step(8'h81, 8'h00, 8'h00, 3'd7, 0, 0, 0, "R8 wrap order");
    step(8'h04, 8'h00, 8'h04, 3'd0, 0, 0, 0, "R4 equal level");
    step(8'h02, 8'h00, 8'h04, 3'd0, 0, 0, 0, "R4 higher fires");
    step(8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 0, "R4 lower blocked");
    step(8'h01, 8'h00, 8'h02, 3'd1, 0, 0, 0, "R4 rotated blocked");
    step(8'h80, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R5 empty service");
    step(8'h08, 8'h04, 8'h04, 3'd0, 1, 0, 0, "R6 special mask");
    step(8'h08, 8'h04, 8'h04, 3'd0, 0, 0, 0, "R6 mode off");
    step(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 1, "R7 nested master");
    step(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 0, "R7 nested slave");
    step(8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 1, "R7 master not nested");
    step(8'h08, 8'h00, 8'h06, 3'd0, 0, 1, 1, "R7 other bit counts");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[7:0], r[15:8] & r[23:16], r[31:24] & $urandom, 3'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), "R2 mixed");
    end
    @(negedge clk_i);
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule